// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

This block receives asynchronous serial characters on a single line. An external rate generator supplies a one-cycle enable sixteen times per bit period, and every timing decision inside the receiver advances only on that enable. Each character is one low start bit, eight data bits sent least significant first, and one high stop bit. The finished byte is moved into a data register that the host reads through a read strobe.

A five-bit status word reports receive-full, overrun, noise, framing error and idle line. Two interrupt enables turn the receive-side flags and the idle flag into a single interrupt request. The host clears every flag by reading the status word and then reading the data register. The idle flag only reports the end of a message: it fires once after a good character and is not raised again until another good character arrives.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, status_out is 0, irq is 0 and data_out is 0.
- R2: A frame (start low, 8 data bits least significant bit first, stop high) places the byte in data_out and sets receive-full, status_out bit 0, one clock after the middle of the stop bit.
- R3: If a frame completes while receive-full is set, overrun (status_out bit 1) is set, the new byte is dropped and data_out keeps the older byte.
- R4: Each bit is decided by the majority of the samples taken at oversample ticks 7, 8 and 9 of the bit; if those three samples are not all equal in any bit of a frame, noise (status_out bit 2) is set when that frame completes, and the byte holds the majority values.
- R5: A stop bit decided low sets framing error (status_out bit 3); the byte is still transferred.
- R6: A low level that is high again by the middle of the start bit is not taken as a start bit; the receiver goes back to searching and later frames are received normally.
- R7: Idle (status_out bit 4) is set after 10 bit times (160 ticks) of continuous high line following a frame with a high stop bit; it is never set before such a frame, and after it has been set it is not set again until another such frame has been received.
- R8: A data read that follows a status read clears all five flags; a data read without a preceding status read leaves the flags unchanged.
- R9: irq is high exactly when (full_irq_en and (receive-full or overrun)) or (idle_irq_en and idle).
- R10: While rx_enable is low, data_out reads 0 and frames on the line are ignored; the stored byte reappears when rx_enable returns high.
- R11: Bit timing follows sample_tick only: with one tick every third clock, a frame whose bits last 48 clocks is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Serial data line, high when idle |
| sample_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_enable | input | 1 | Receiver enable |
| full_irq_en | input | 1 | Interrupt enable for receive-full and overrun |
| idle_irq_en | input | 1 | Interrupt enable for idle line |
| rd_status | input | 1 | Host read strobe for the status word |
| rd_data | input | 1 | Host read strobe for the data register |
| status_out | output | 5 | Flags: bit 0 full, 1 overrun, 2 noise, 3 framing, 4 idle |
| data_out | output | 8 | Last received byte, 0 while disabled |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches on every cycle that the interrupt request follows the flags and their enables, that no flag ever drops except right after a data read, that an overrun never disturbs the stored byte, and that the data output is zero while the receiver is disabled. Majority voting on a glitched bit, rejection of a short start pulse, the idle flag's arming after a good character, the two-step clear and timing at a slower tick rate all depend on whole frames on the line, so only the directed scenarios of the bench can show them.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    // Bit 0 full, 1 overrun, 2 noise, 3 framing, 4 idle.
    typedef struct packed {
        logic idle;
        logic framing;
        logic noise;
        logic overrun;
        logic full;
    } rx_flags_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/srx_bit_engine.sv
module srx_bit_engine
    import srx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 tick,
    input  logic                 line_s,
    output logic                 hunting,
    output logic                 frame_done,
    output logic [DATA_BITS-1:0] frame_byte,
    output logic                 frame_stop_ok,
    output logic                 frame_noisy
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0] C_LAST = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] C_S0   = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] C_S1   = CW'(OVERSAMPLE / 2);
    localparam logic [CW-1:0] C_S2   = CW'(OVERSAMPLE / 2 + 1);
    localparam logic [IW-1:0] I_LAST = IW'(DATA_BITS - 1);

    rx_state_e            state;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        bit_idx;
    logic                 s0, s1;
    logic                 noisy;
    logic [DATA_BITS-1:0] shreg;
    logic                 vote, disagree;

    always_comb begin
        vote     = vote3(s0, s1, line_s);
        disagree = !((s0 == s1) && (s1 == line_s));
    end

    assign hunting    = (state == ST_HUNT);
    assign frame_byte = shreg;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state         <= ST_HUNT;
            cnt           <= '0;
            bit_idx       <= '0;
            s0            <= 1'b1;
            s1            <= 1'b1;
            noisy         <= 1'b0;
            shreg         <= '0;
            frame_done    <= 1'b0;
            frame_stop_ok <= 1'b0;
            frame_noisy   <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (tick) begin
                if (state == ST_HUNT) begin
                    if (!line_s) begin
                        state <= ST_START;
                        cnt   <= CW'(1);
                        noisy <= 1'b0;
                    end
                end else begin
                    cnt <= (cnt == C_LAST) ? '0 : cnt + CW'(1);
                    if (cnt == C_S0) s0 <= line_s;
                    if (cnt == C_S1) s1 <= line_s;
                    if (cnt == C_S2) begin
                        noisy <= noisy | disagree;
                        case (state)
                            ST_START: if (vote) begin
                                state <= ST_HUNT;
                                cnt   <= '0;
                            end
                            ST_DATA: shreg <= {vote, shreg[DATA_BITS-1:1]};
                            ST_STOP: begin
                                frame_done    <= 1'b1;
                                frame_stop_ok <= vote;
                                frame_noisy   <= noisy | disagree;
                                state         <= ST_HUNT;
                                cnt           <= '0;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt == C_LAST) begin
                        if (state == ST_START) begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                        end else if (state == ST_DATA) begin
                            if (bit_idx == I_LAST) state <= ST_STOP;
                            else bit_idx <= bit_idx + IW'(1);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/srx_idle_watch.sv
module srx_idle_watch #(
    parameter int OVERSAMPLE = 16,
    parameter int IDLE_BITS  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tick,
    input  logic line_s,
    input  logic hunting,
    output logic idle_hit
);
    localparam int LIMIT = IDLE_BITS * OVERSAMPLE;
    localparam int LW    = $clog2(LIMIT + 1);
    localparam logic [LW-1:0] L_MAX = LW'(LIMIT);
    localparam logic [LW-1:0] L_PRE = LW'(LIMIT - 1);

    logic [LW-1:0] run;

    assign idle_hit = enable && tick && hunting && line_s && (run == L_PRE);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run <= '0;
        end else if (tick) begin
            if (!hunting || !line_s) run <= '0;
            else if (run != L_MAX) run <= run + LW'(1);
        end
    end
endmodule

// File: rtl/srx_status_regs.sv
module srx_status_regs
    import srx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_done,
    input  logic [DATA_BITS-1:0] frame_byte,
    input  logic                 frame_stop_ok,
    input  logic                 frame_noisy,
    input  logic                 idle_hit,
    input  logic                 rd_status,
    input  logic                 rd_data,
    output rx_flags_t            flags,
    output logic [DATA_BITS-1:0] data_q
);
    rx_flags_t            nf;
    logic [DATA_BITS-1:0] nd;
    logic                 armed, na;
    logic                 seen;

    always_comb begin
        nf = flags;
        nd = data_q;
        na = armed;
        if (rd_data && seen) nf = '0;
        if (frame_done) begin
            if (nf.full) begin
                nf.overrun = 1'b1;
            end else begin
                nf.full = 1'b1;
                nd      = frame_byte;
            end
            if (!frame_stop_ok) nf.framing = 1'b1;
            if (frame_noisy)    nf.noise   = 1'b1;
            if (frame_stop_ok)  na         = 1'b1;
        end
        if (idle_hit && na) begin
            nf.idle = 1'b1;
            na      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            data_q <= '0;
            armed  <= 1'b0;
            seen   <= 1'b0;
        end else begin
            flags  <= nf;
            data_q <= nd;
            armed  <= na;
            if (rd_status)    seen <= 1'b1;
            else if (rd_data) seen <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import srx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8,
    parameter int IDLE_BITS  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    input  logic                 sample_tick,
    input  logic                 rx_enable,
    input  logic                 full_irq_en,
    input  logic                 idle_irq_en,
    input  logic                 rd_status,
    input  logic                 rd_data,
    output logic [4:0]           status_out,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 irq
);
    logic [1:0]           sync_q;
    logic                 line_s;
    logic                 hunting, frame_done, frame_stop_ok, frame_noisy, idle_hit;
    logic [DATA_BITS-1:0] frame_byte, data_q;
    rx_flags_t            flags;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rx_line};
    end
    assign line_s = sync_q[1];

    srx_bit_engine #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_engine (
        .clk(clk), .rst(rst), .enable(rx_enable), .tick(sample_tick), .line_s(line_s),
        .hunting(hunting), .frame_done(frame_done), .frame_byte(frame_byte),
        .frame_stop_ok(frame_stop_ok), .frame_noisy(frame_noisy)
    );

    srx_idle_watch #(.OVERSAMPLE(OVERSAMPLE), .IDLE_BITS(IDLE_BITS)) u_idle (
        .clk(clk), .rst(rst), .enable(rx_enable), .tick(sample_tick), .line_s(line_s),
        .hunting(hunting), .idle_hit(idle_hit)
    );

    srx_status_regs #(.DATA_BITS(DATA_BITS)) u_regs (
        .clk(clk), .rst(rst), .frame_done(frame_done), .frame_byte(frame_byte),
        .frame_stop_ok(frame_stop_ok), .frame_noisy(frame_noisy), .idle_hit(idle_hit),
        .rd_status(rd_status), .rd_data(rd_data), .flags(flags), .data_q(data_q)
    );

    assign status_out = flags;
    assign data_out   = rx_enable ? data_q : '0;
    assign irq        = (full_irq_en && (flags.full || flags.overrun)) ||
                        (idle_irq_en && flags.idle);
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rx_enable,
    input logic                 full_irq_en,
    input logic                 idle_irq_en,
    input logic                 rd_data,
    input logic [4:0]           status_out,
    input logic [DATA_BITS-1:0] data_out,
    input logic                 irq
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (status_out == 5'd0 && data_out == '0));

    // R9
    irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq == ((full_irq_en && (status_out[0] || status_out[1])) || (idle_irq_en && status_out[4])));

    // R8
    flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(status_out) & ~status_out)) |-> $past(rd_data));

    // R3
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(status_out[1]) && rx_enable && $past(rx_enable)) |-> $stable(data_out));

    // R10
    disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |-> (data_out == '0));
endmodule

bind serial_rx_status srx_checker #(.DATA_BITS(DATA_BITS)) u_srx_checker (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .full_irq_en(full_irq_en),
    .idle_irq_en(idle_irq_en), .rd_data(rd_data), .status_out(status_out),
    .data_out(data_out), .irq(irq)
);

// File: tb/test_serial_rx_status.sv
module test_serial_rx_status;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       sample_tick = 1'b1;
    logic       rx_enable = 1'b1;
    logic       full_irq_en = 1'b0;
    logic       idle_irq_en = 1'b0;
    logic       rd_status = 1'b0;
    logic       rd_data = 1'b0;
    logic [4:0] status_out;
    logic [7:0] data_out;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int tick_div = 1;
    int div_cnt = 0;
    bit finished = 0;

    serial_rx_status i_serial_rx_status (
        .clk(clk), .rst(rst), .rx_line(rx_line), .sample_tick(sample_tick),
        .rx_enable(rx_enable), .full_irq_en(full_irq_en), .idle_irq_en(idle_irq_en),
        .rd_status(rd_status), .rd_data(rd_data), .status_out(status_out),
        .data_out(data_out), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        div_cnt     = (div_cnt + 1) % tick_div;
        sample_tick = (div_cnt == 0);
    end

    task automatic check(input string req, input string what, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // glitch_bit: data bit index to invert for one clock near its middle, -1 for none
    task automatic send_frame(input logic [7:0] b, input logic stop_v, input int glitch_bit);
        int bt;
        bt = 16 * tick_div;
        @(negedge clk);
        rx_line = 1'b0;
        wait_clks(bt);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            if (i == glitch_bit) begin
                wait_clks(8);
                rx_line = ~b[i];
                wait_clks(1);
                rx_line = b[i];
                wait_clks(bt - 9);
            end else begin
                wait_clks(bt);
            end
        end
        rx_line = stop_v;
        wait_clks(bt);
        rx_line = 1'b1;
        wait_clks(2);
    endtask

    task automatic pulse_status();
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
    endtask

    task automatic pulse_data();
        @(negedge clk) rd_data = 1'b1;
        @(negedge clk) rd_data = 1'b0;
    endtask

    task automatic clear_flags();
        pulse_status();
        pulse_data();
        wait_clks(1);
    endtask

    task automatic test_reset();
        check("R1", "status after reset", status_out, 0);
        check("R1", "irq after reset", irq, 0);
        check("R1", "data after reset", data_out, 0);
    endtask

    task automatic test_idle_unarmed();
        wait_clks(400);
        check("R7", "idle before any frame", status_out[4], 0);
    endtask

    task automatic test_basic_and_idle();
        send_frame(8'hA5, 1'b1, -1);
        check("R2", "full after frame", status_out[0], 1);
        check("R2", "byte A5", data_out, 8'hA5);
        check("R7", "idle not yet", status_out[4], 0);
        check("R9", "irq with enables off", irq, 0);
        wait_clks(200);
        check("R7", "idle after 10 bit times", status_out[4], 1);
        idle_irq_en = 1'b1;
        wait_clks(1);
        check("R9", "irq from idle", irq, 1);
        idle_irq_en = 1'b0;
        pulse_data();
        wait_clks(1);
        check("R8", "data read alone keeps flags", status_out, 5'b10001);
        clear_flags();
        check("R8", "status then data clears", status_out, 0);
        wait_clks(300);
        check("R7", "idle not raised again", status_out[4], 0);
    endtask

    task automatic test_overrun();
        full_irq_en = 1'b1;
        send_frame(8'h3C, 1'b1, -1);
        check("R9", "irq from full", irq, 1);
        send_frame(8'hC3, 1'b1, -1);
        check("R3", "overrun flag", status_out[1], 1);
        check("R3", "old byte kept", data_out, 8'h3C);
        clear_flags();
        check("R8", "cleared after overrun", status_out, 0);
        check("R9", "irq gone", irq, 0);
        full_irq_en = 1'b0;
    endtask

    task automatic test_noise();
        send_frame(8'h0F, 1'b1, 2);
        check("R4", "noise flag", status_out[2], 1);
        check("R4", "majority byte", data_out, 8'h0F);
        clear_flags();
        send_frame(8'h5A, 1'b1, -1);
        check("R4", "clean frame no noise", status_out[2], 0);
        clear_flags();
    endtask

    task automatic test_framing();
        send_frame(8'h55, 1'b0, -1);
        wait_clks(40);
        check("R5", "framing flag", status_out[3], 1);
        check("R5", "byte still moved", data_out, 8'h55);
        check("R5", "full set", status_out[0], 1);
        clear_flags();
    endtask

    task automatic test_false_start();
        @(negedge clk) rx_line = 1'b0;
        wait_clks(4);
        rx_line = 1'b1;
        wait_clks(40);
        check("R6", "short pulse ignored", status_out[0], 0);
        send_frame(8'h81, 1'b1, -1);
        check("R6", "next frame received", data_out, 8'h81);
        clear_flags();
    endtask

    task automatic test_disable();
        rx_enable = 1'b0;
        wait_clks(1);
        check("R10", "data zero when disabled", data_out, 0);
        send_frame(8'h77, 1'b1, -1);
        check("R10", "frame ignored", status_out[0], 0);
        rx_enable = 1'b1;
        wait_clks(1);
        check("R10", "stored byte back", data_out, 8'h81);
    endtask

    task automatic test_slow_tick();
        tick_div = 3;
        wait_clks(20);
        send_frame(8'h6B, 1'b1, -1);
        wait_clks(10);
        check("R11", "full at slow tick", status_out[0], 1);
        check("R11", "byte at slow tick", data_out, 8'h6B);
        clear_flags();
        tick_div = 1;
    endtask

    initial begin
        wait_clks(4);
        rst = 1'b0;
        wait_clks(2);
        test_reset();
        test_idle_unarmed();
        test_basic_and_idle();
        test_overrun();
        test_noise();
        test_framing();
        test_false_start();
        test_disable();
        test_slow_tick();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule